// File: doc/BRIEF.md
# Burst-Mode Loop Synchronization Controller

This block manages loop synchronization for one burst-mode transmission line. The same logic serves either end of the loop. The `master_mode` strap selects the role. Once per 4 kHz line frame the block gets a receive-frame strobe and two per-frame flags:

- a burst-energy flag, meaning something was heard on the line;
- a mark flag, meaning a correctly formatted burst carrying its framing mark arrived.

From these flags it keeps an in-sync or hunting state, spots a far-end wake-up request, and decides when its own transmit bursts go out. Analog detection, scrambling, burst shaping and clock recovery stay outside. They are represented by the strobe and flag inputs.

A master sends one burst on each frame-sync strobe, but only once its line enable is set. A slave that starts activation on its own sends bursts on every other tick of its local oscillator. As soon as it hears a burst from the far end, it re-times to the received frames and answers once per frame. Gaining sync, losing sync and detecting a wake-up are each reported as one-cycle event pulses. A status and interrupt block latches these pulses. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `loop_sync_ctrl`

## Requirements
- R1: After reset, `in_sync`, `tx_burst`, `evt_sync_gain`, `evt_sync_loss`, `evt_wake`, `wake_pending` and `slave_retimed` are all 0.
- R2: While hunting, `in_sync` goes to 1 after ACQ_RUN (default 4) consecutive `rx_tick` frames with `rx_mark`=1. Any frame with `rx_mark`=0 restarts the run.
- R3: While in sync, `in_sync` returns to 0 after LOSS_RUN (default 4) consecutive `rx_tick` frames with `rx_mark`=0. Any marked frame restarts the run, and after the loss the block hunts again.
- R4: `evt_sync_gain` and `evt_sync_loss` are one-cycle pulses. They appear in the cycle after the deciding `rx_tick`, and the two are never high together.
- R5: With `master_mode`=1, `tx_burst` pulses in the cycle after each `fs_tick` seen while `line_enable`=1, and at no other time.
- R6: With `master_mode`=0, `slave_retimed`=0 and `slave_wake_req`=1, `tx_burst` pulses after the 1st, 3rd, 5th … `osc_tick`, and not after the others.
- R7: With `master_mode`=0, an `rx_tick` with `rx_burst`=1 sets `slave_retimed`. From that frame on, `tx_burst` follows every `rx_tick` and `osc_tick` is ignored. A sync loss clears `slave_retimed`, and it is never set in master mode.
- R8: In master mode, while hunting, with `line_enable`=0, the alternation count is tracked as follows:
  - It rises by one on each `rx_tick` whose `rx_burst` differs from the previous frame's flag. The flag before the first frame counts as 0.
  - It drops to 0 otherwise.
  - It saturates at WAKE_ALT (default 3).

  When the count reaches WAKE_ALT on a frame with `rx_burst`=1, `wake_pending` is set, and `evt_wake` pulses once if `wake_pending` was 0.
- R9: `line_enable`=1 clears `wake_pending` on the next clock.
- R10: Dropping `slave_wake_req` resets the alternate-frame phase, so the next wake-up again transmits on its first `osc_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = master end, 0 = slave end |
| line_enable | input | 1 | Control-register line enable (master transmit permit) |
| slave_wake_req | input | 1 | Slave request to start activation |
| fs_tick | input | 1 | Master frame-sync strobe, one cycle per frame |
| osc_tick | input | 1 | Slave local-oscillator frame strobe |
| rx_tick | input | 1 | Received-frame strobe qualifying rx_mark and rx_burst |
| rx_mark | input | 1 | Correctly formatted burst with framing mark this frame |
| rx_burst | input | 1 | Burst energy detected this frame |
| tx_burst | output | 1 | One-cycle command to send a burst |
| in_sync | output | 1 | Loop synchronization held |
| evt_sync_gain | output | 1 | Pulse: sync acquired |
| evt_sync_loss | output | 1 | Pulse: sync lost |
| evt_wake | output | 1 | Pulse: far-end wake-up detected |
| wake_pending | output | 1 | Wake-up seen and not yet answered |
| slave_retimed | output | 1 | Slave locked to received burst timing |

## Verification
The bench uses the default ACQ_RUN=4, LOSS_RUN=4 and WAKE_ALT=3. With these values a 10-frame mark sequence is long enough to acquire sync, lose it and begin hunting again. Every one of the 1024 mark sequences is applied against a run-length model held in the bench. Every 8-frame burst-presence sequence is swept through wake detection, which covers each alternation run that reaches or misses the threshold of three. The role, enable and wake-request cases of the transmit scheduler are then walked explicitly.

// File: rtl/loop_sync_pkg.sv
package loop_sync_pkg;

  typedef enum logic {
    SYNC_HUNT = 1'b0,
    SYNC_HELD = 1'b1
  } sync_state_t;

  typedef struct packed {
    logic gain;
    logic loss;
  } sync_evt_t;

endpackage

// File: rtl/loop_sync_tracker.sv
module loop_sync_tracker
  import loop_sync_pkg::*;
#(
  parameter int ACQ_RUN  = 4,
  parameter int LOSS_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_tick,
  input  logic rx_mark,
  output logic in_sync,
  output logic evt_gain,
  output logic evt_loss
);

  localparam int RUN_MAX = (ACQ_RUN > LOSS_RUN) ? ACQ_RUN : LOSS_RUN;
  localparam int CW      = $clog2(RUN_MAX + 1);
  localparam logic [CW-1:0] ACQ_LIM  = CW'(ACQ_RUN);
  localparam logic [CW-1:0] LOSS_LIM = CW'(LOSS_RUN);

  sync_state_t   state_q, state_d;
  logic [CW-1:0] run_q, run_d;
  sync_evt_t     evt_q, evt_d;
  logic          upd_en;

  assign upd_en = rx_tick;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    evt_d   = '0;
    if (upd_en) begin
      if (state_q == SYNC_HUNT) begin
        if (rx_mark) begin
          if (run_q + 1'b1 >= ACQ_LIM) begin
            state_d  = SYNC_HELD;
            run_d    = '0;
            evt_d.gain = 1'b1;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          run_d = '0;
        end
      end else begin
        if (!rx_mark) begin
          if (run_q + 1'b1 >= LOSS_LIM) begin
            state_d  = SYNC_HUNT;
            run_d    = '0;
            evt_d.loss = 1'b1;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          run_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SYNC_HUNT;
      run_q   <= '0;
      evt_q   <= '0;
    end else begin
      evt_q <= evt_d;
      if (upd_en) begin
        state_q <= state_d;
        run_q   <= run_d;
      end
    end
  end

  assign in_sync  = (state_q == SYNC_HELD);
  assign evt_gain = evt_q.gain;
  assign evt_loss = evt_q.loss;

  assert_gain_on_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_gain |-> $past(rx_tick && rx_mark));
  assert_gain_holds_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_gain |-> in_sync);
  assert_loss_on_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_loss |-> ($past(rx_tick && !rx_mark) && !in_sync));
  assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < CW'(RUN_MAX));
  assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_gain, evt_loss}));

endmodule

// File: rtl/loop_wake_detect.sv
module loop_wake_detect #(
  parameter int WAKE_ALT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic line_enable,
  input  logic in_sync,
  input  logic rx_tick,
  input  logic rx_burst,
  output logic wake_pending,
  output logic evt_wake
);

  localparam int AW = $clog2(WAKE_ALT + 1);
  localparam logic [AW-1:0] ALT_LIM = AW'(WAKE_ALT);

  logic          armed;
  logic          prev_q, prev_d;
  logic [AW-1:0] alt_q, alt_d;
  logic          pend_q, pend_d;
  logic          evt_q, evt_d;

  assign armed = master_mode && !in_sync && !line_enable;

  always_comb begin
    prev_d = prev_q;
    alt_d  = alt_q;
    pend_d = pend_q;
    evt_d  = 1'b0;
    if (!armed) begin
      prev_d = 1'b0;
      alt_d  = '0;
      if (line_enable) pend_d = 1'b0;
    end else if (rx_tick) begin
      prev_d = rx_burst;
      if (rx_burst != prev_q) begin
        alt_d = (alt_q >= ALT_LIM) ? ALT_LIM : alt_q + 1'b1;
      end else begin
        alt_d = '0;
      end
      if (rx_burst && alt_d >= ALT_LIM) begin
        pend_d = 1'b1;
        evt_d  = !pend_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      alt_q  <= '0;
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      alt_q  <= alt_d;
      pend_q <= pend_d;
      evt_q  <= evt_d;
    end
  end

  assign wake_pending = pend_q;
  assign evt_wake     = evt_q;

  assert_wake_on_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wake |-> ($past(rx_tick && rx_burst && master_mode && !line_enable) && wake_pending));
  assert_wake_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wake |-> !$past(wake_pending));
  assert_enable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_enable) |-> !wake_pending);

endmodule

// File: rtl/loop_burst_sched.sv
module loop_burst_sched (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic line_enable,
  input  logic slave_wake_req,
  input  logic fs_tick,
  input  logic osc_tick,
  input  logic rx_tick,
  input  logic rx_burst,
  input  logic sync_lost,
  output logic tx_burst,
  output logic retimed
);

  logic tx_q, tx_d;
  logic rt_q, rt_d;
  logic ph_q, ph_d;
  logic heard;

  assign heard = rx_tick && rx_burst;

  always_comb begin
    tx_d = 1'b0;
    rt_d = rt_q;
    ph_d = ph_q;
    if (master_mode) begin
      tx_d = fs_tick && line_enable;
      rt_d = 1'b0;
      ph_d = 1'b0;
    end else begin
      if (sync_lost)  rt_d = 1'b0;
      else if (heard) rt_d = 1'b1;
      if (rt_q || heard) begin
        tx_d = rx_tick;
        ph_d = 1'b0;
      end else if (slave_wake_req) begin
        if (osc_tick) begin
          tx_d = !ph_q;
          ph_d = !ph_q;
        end
      end else begin
        ph_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b0;
      rt_q <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      tx_q <= tx_d;
      rt_q <= rt_d;
      ph_q <= ph_d;
    end
  end

  assign tx_burst = tx_q;
  assign retimed  = rt_q;

  assert_master_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_burst && $past(master_mode)) |-> $past(fs_tick && line_enable));
  assert_slave_tx_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_burst && !$past(master_mode)) |-> $past(rx_tick || (osc_tick && slave_wake_req)));
  assert_no_master_retime_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(master_mode) |-> !retimed);

endmodule

// File: rtl/loop_sync_ctrl.sv
module loop_sync_ctrl #(
  parameter int ACQ_RUN  = 4,
  parameter int LOSS_RUN = 4,
  parameter int WAKE_ALT = 3,
  parameter int RST_SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic line_enable,
  input  logic slave_wake_req,
  input  logic fs_tick,
  input  logic osc_tick,
  input  logic rx_tick,
  input  logic rx_mark,
  input  logic rx_burst,
  output logic tx_burst,
  output logic in_sync,
  output logic evt_sync_gain,
  output logic evt_sync_loss,
  output logic evt_wake,
  output logic wake_pending,
  output logic slave_retimed
);

  logic [RST_SYNC-1:0] rst_pipe;
  logic                rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[RST_SYNC-1];

  loop_sync_tracker #(
    .ACQ_RUN  (ACQ_RUN),
    .LOSS_RUN (LOSS_RUN)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rx_tick  (rx_tick),
    .rx_mark  (rx_mark),
    .in_sync  (in_sync),
    .evt_gain (evt_sync_gain),
    .evt_loss (evt_sync_loss)
  );

  loop_wake_detect #(
    .WAKE_ALT (WAKE_ALT)
  ) u_wake (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .master_mode  (master_mode),
    .line_enable  (line_enable),
    .in_sync      (in_sync),
    .rx_tick      (rx_tick),
    .rx_burst     (rx_burst),
    .wake_pending (wake_pending),
    .evt_wake     (evt_wake)
  );

  loop_burst_sched u_sched (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .master_mode    (master_mode),
    .line_enable    (line_enable),
    .slave_wake_req (slave_wake_req),
    .fs_tick        (fs_tick),
    .osc_tick       (osc_tick),
    .rx_tick        (rx_tick),
    .rx_burst       (rx_burst),
    .sync_lost      (evt_sync_loss),
    .tx_burst       (tx_burst),
    .retimed        (slave_retimed)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_int_n |=> (!in_sync && !tx_burst && !wake_pending && !slave_retimed));

endmodule

// File: tb/loop_sync_ctrl_tb.sv
module loop_sync_ctrl_tb;

  localparam int ACQ = 4;
  localparam int LOSS = 4;
  localparam int WALT = 3;

  logic clk, rst_n, master_mode, line_enable, slave_wake_req;
  logic fs_tick, osc_tick, rx_tick, rx_mark, rx_burst;
  logic tx_burst, in_sync, evt_sync_gain, evt_sync_loss, evt_wake, wake_pending, slave_retimed;

  int checks = 0;
  int errors = 0;

  loop_sync_ctrl #(.ACQ_RUN(ACQ), .LOSS_RUN(LOSS), .WAKE_ALT(WALT)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .line_enable(line_enable),
    .slave_wake_req(slave_wake_req), .fs_tick(fs_tick), .osc_tick(osc_tick),
    .rx_tick(rx_tick), .rx_mark(rx_mark), .rx_burst(rx_burst), .tx_burst(tx_burst),
    .in_sync(in_sync), .evt_sync_gain(evt_sync_gain), .evt_sync_loss(evt_sync_loss),
    .evt_wake(evt_wake), .wake_pending(wake_pending), .slave_retimed(slave_retimed)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input logic fs, input logic osc, input logic rt, input logic mk, input logic bu);
    fs_tick = fs; osc_tick = osc; rx_tick = rt; rx_mark = mk; rx_burst = bu;
    @(posedge clk);
    @(negedge clk);
    fs_tick = 1'b0; osc_tick = 1'b0; rx_tick = 1'b0; rx_mark = 1'b0; rx_burst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    master_mode = 1'b1; line_enable = 1'b0; slave_wake_req = 1'b0;
    fs_tick = 1'b0; osc_tick = 1'b0; rx_tick = 1'b0; rx_mark = 1'b0; rx_burst = 1'b0;
    rst_n = 1'b0;
    do_reset();
    chk("R1", "in_sync", in_sync, 1'b0);
    chk("R1", "tx_burst", tx_burst, 1'b0);
    chk("R1", "evt_sync_gain", evt_sync_gain, 1'b0);
    chk("R1", "evt_sync_loss", evt_sync_loss, 1'b0);
    chk("R1", "evt_wake", evt_wake, 1'b0);
    chk("R1", "wake_pending", wake_pending, 1'b0);
    chk("R1", "slave_retimed", slave_retimed, 1'b0);

    // R2 R3 R4: exhaustive 10-frame mark sweep against a run-length model
    line_enable = 1'b1;
    for (int p = 0; p < 1024; p++) begin
      int  st, cnt;
      logic g, l;
      do_reset();
      st = 0; cnt = 0;
      for (int f = 0; f < 10; f++) begin
        logic m;
        m = p[f];
        g = 1'b0; l = 1'b0;
        if (st == 0) begin
          if (m) begin cnt++; if (cnt == ACQ) begin st = 1; cnt = 0; g = 1'b1; end end
          else cnt = 0;
        end else begin
          if (!m) begin cnt++; if (cnt == LOSS) begin st = 0; cnt = 0; l = 1'b1; end end
          else cnt = 0;
        end
        step(1'b0, 1'b0, 1'b1, m, m);
        chk(st == 1 ? "R2" : "R3", "in_sync", in_sync, st[0]);
        chk("R4", "evt_sync_gain", evt_sync_gain, g);
        chk("R4", "evt_sync_loss", evt_sync_loss, l);
      end
    end

    // R8: exhaustive 8-frame burst sweep for wake detection
    line_enable = 1'b0;
    for (int p = 0; p < 256; p++) begin
      int  alt;
      logic prv, pend, ev;
      do_reset();
      alt = 0; prv = 1'b0; pend = 1'b0;
      for (int f = 0; f < 8; f++) begin
        logic b;
        b = p[f];
        ev = 1'b0;
        if (b != prv) alt = (alt >= WALT) ? WALT : alt + 1;
        else alt = 0;
        prv = b;
        if (b && alt >= WALT) begin ev = !pend; pend = 1'b1; end
        step(1'b0, 1'b0, 1'b1, 1'b0, b);
        chk("R8", "evt_wake", evt_wake, ev);
        chk("R8", "wake_pending", wake_pending, pend);
      end
    end

    // R9: enable clears the pending wake-up
    do_reset();
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R8", "wake_pending set", wake_pending, 1'b1);
    line_enable = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "wake_pending cleared", wake_pending, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R9", "no wake while enabled", evt_wake, 1'b0);
    chk("R9", "pending stays clear", wake_pending, 1'b0);

    // R5: master transmit across role and enable
    for (int c = 0; c < 4; c++) begin
      master_mode = c[1]; line_enable = c[0]; slave_wake_req = 1'b0;
      do_reset();
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R5", "tx after fs_tick", tx_burst, c[1] & c[0]);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R5", "no tx without fs_tick", tx_burst, 1'b0);
    end

    // R6 R10: slave wake-up on alternate oscillator ticks
    master_mode = 1'b0; line_enable = 1'b0; slave_wake_req = 1'b1;
    do_reset();
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R6", "alternate tx", tx_burst, (k % 2) == 0);
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R6", "no tx between ticks", tx_burst, 1'b0);
    end
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6", "tick 7 tx", tx_burst, 1'b1);
    slave_wake_req = 1'b0;
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10", "no tx when request dropped", tx_burst, 1'b0);
    slave_wake_req = 1'b1;
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10", "phase restarts on new request", tx_burst, 1'b1);

    // R7: slave re-times to received bursts
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7", "tx on first heard burst", tx_burst, 1'b1);
    chk("R7", "retimed set", slave_retimed, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7", "osc_tick ignored", tx_burst, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7", "tx per rx frame", tx_burst, 1'b1);
    for (int k = 0; k < ACQ; k++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R2", "slave in sync", in_sync, 1'b1);
    for (int k = 0; k < LOSS; k++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3", "slave lost sync", evt_sync_loss, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7", "retimed cleared by loss", slave_retimed, 1'b0);
    slave_wake_req = 1'b0;
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7", "no tx after loss without burst", tx_burst, 1'b0);
    master_mode = 1'b1;
    do_reset();
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7", "master never retimes", slave_retimed, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule